// File: doc/BRIEF.md
# Signed-Delta Weight Update Pulse Controller

This block runs the weight-update step of an on-chip learning array in which every weight is held as a difference between two storage devices, one carrying the positive share and one the negative share. When an update starts, it latches one last-step spike bit per presynaptic row and one signed error term per postsynaptic column. A selected row is one whose spike bit is 1. An active column is one whose error term is nonzero after optional derivative gating. Every cell at a selected row and an active column is written in the same pulse window, and every other cell is inhibited.

For each column the controller picks the pulse kind for both devices from the sign of the error term. It computes a pulse length in clock ticks from the error magnitude scaled by a learning-rate register that software can rewrite, and it counts that length down. The outputs are a row enable vector and, per column, an active flag plus program/erase commands for the positive and negative devices. A done flag marks the cycle in which every column counter has drained.

Top module: `wupd_ctrl`

## Requirements
- R1: After reset, all row enables, column actives, device commands, busy and done are 0, and the learning-rate register holds 16, which means a gain of 1.0 in unsigned Q4.4.
- R2: A start while busy is 0 is accepted. From the next cycle, row_en equals the pre_spike vector captured at the accepted start, for as long as any column is active. row_en is 0 at all other times.
- R3: Each column's pulse length in ticks is min(MAX_W, (|delta| * lr) >> 4). Delta is a two's-complement DW-bit field, column c at bits [c*DW +: DW]. A column whose length is 0 stays inactive.
- R4: When a column's delta is positive (weight increase), the positive device gets an erase and the negative device gets a program for the whole pulse.
- R5: When a column's delta is negative (weight decrease), the positive device gets a program and the negative device gets an erase for the whole pulse.
- R6: The program command and the erase command of one column are asserted over exactly the same cycles, so both devices receive pulses of equal width.
- R7: When hidden_mode is 1, a column whose deriv_flag bit is 0 is treated as having a zero delta. When hidden_mode is 0, the deriv_flag bits have no effect.
- R8: All columns with a nonzero length go active in the same cycle, the one right after the accepted start, and stay active for exactly their length.
- R9: Writing lr_in with lr_we changes the gain that later accepted starts use. A pulse already running keeps its length.
- R10: A start that arrives while any column is active is ignored. Pulses, row enables and pulse kinds continue unchanged.
- R11: done is 1 for exactly one cycle: the first cycle after an accepted start in which no column is active. If every length is 0, that is the cycle right after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an update phase |
| lr_we | input | 1 | Write strobe for the learning-rate register |
| lr_in | input | LRW | New learning rate, unsigned Q4.4 |
| hidden_mode | input | 1 | Gate deltas with the derivative flags |
| pre_spike | input | ROWS | Last-step spike bit per presynaptic row |
| deriv_flag | input | COLS | Stored derivative bit per postsynaptic column |
| delta_flat | input | COLS*DW | Signed delta per column, packed |
| row_en | output | ROWS | Row select during the pulse window |
| col_active | output | COLS | Column pulse in progress |
| pos_pgm | output | COLS | Program command, positive device |
| pos_ers | output | COLS | Erase command, positive device |
| neg_pgm | output | COLS | Program command, negative device |
| neg_ers | output | COLS | Erase command, negative device |
| busy | output | 1 | Any column active |
| done | output | 1 | One-cycle phase completion flag |

## Verification
A corrupted column counter makes that column's active flag end early or late. This shows at the ports within the pulse it corrupts, because the bench checks every tick of every pulse against the computed length. A wrong latched sign swaps the program and erase outputs from the first active cycle. A row latch or phase flag in the wrong state shows as a row enable or done flag in the wrong cycle of the same phase. A reload while busy changes lengths from the next cycle on, which the mid-pulse start probes catch.

// File: rtl/wupd_pkg.sv
package wupd_pkg;

    // Fractional bits of the learning-rate register (Q4.4 by default).
    localparam int LR_FRAC = 4;

    // Per-column pulse decision carried between the width unit and the column timer.
    typedef struct packed {
        logic        neg;   // 1: weight decrease
        logic [31:0] len;   // ticks, already saturated
    } pulse_req_t;

    // Scale magnitude by learning rate, drop fractional bits, clip to limit.
    function automatic logic [31:0] scale_sat(input logic [31:0] mag,
                                              input logic [31:0] lr,
                                              input logic [31:0] limit);
        logic [63:0] prod;
        prod = (64'(mag) * 64'(lr)) >> LR_FRAC;
        if (prod > 64'(limit))
            return limit;
        return prod[31:0];
    endfunction

endpackage

// File: rtl/wupd_width.sv
module wupd_width
    import wupd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LRW   = 8,
    parameter int MAX_W = 200
) (
    input  logic signed [DW-1:0] delta,
    input  logic                 gate_off,
    input  logic [LRW-1:0]       lr,
    output pulse_req_t           req
);
    logic [DW-1:0] mag;

    always_comb begin
        mag = delta[DW-1] ? DW'(-delta) : DW'(delta);
        if (gate_off)
            mag = '0;
        req.len = scale_sat(32'(mag), 32'(lr), 32'(MAX_W));
        req.neg = delta[DW-1] && (req.len != 0);
    end
endmodule

// File: rtl/wupd_col.sv
module wupd_col
    import wupd_pkg::*;
#(
    parameter int CNTW = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  pulse_req_t req,
    output logic       active,
    output logic       pos_pgm,
    output logic       pos_ers,
    output logic       neg_pgm,
    output logic       neg_ers
);
    logic [CNTW-1:0] cnt_q;
    logic            neg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            neg_q <= 1'b0;
        end else if (load) begin
            cnt_q <= CNTW'(req.len);
            neg_q <= req.neg;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        active  = (cnt_q != '0);
        pos_pgm = active &  neg_q;
        pos_ers = active & ~neg_q;
        neg_pgm = active & ~neg_q;
        neg_ers = active &  neg_q;
    end

    // R10
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6
    pair_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({pos_pgm, pos_ers, neg_pgm, neg_ers}) == (active ? 2 : 0)));

    // R5
    kind_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(pos_pgm));
endmodule

// File: rtl/wupd_rows.sv
module wupd_rows #(
    parameter int ROWS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [ROWS-1:0] spikes,
    input  logic            busy,
    output logic [ROWS-1:0] row_en
);
    logic [ROWS-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (load)
            sel_q <= spikes;
    end

    assign row_en = busy ? sel_q : '0;

    // R2
    row_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (|row_en) |-> busy);
endmodule

// File: rtl/wupd_ctrl.sv
module wupd_ctrl
    import wupd_pkg::*;
#(
    parameter int ROWS    = 4,
    parameter int COLS    = 4,
    parameter int DW      = 8,
    parameter int LRW     = 8,
    parameter int MAX_W   = 200,
    parameter int LR_INIT = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 lr_we,
    input  logic [LRW-1:0]       lr_in,
    input  logic                 hidden_mode,
    input  logic [ROWS-1:0]      pre_spike,
    input  logic [COLS-1:0]      deriv_flag,
    input  logic [COLS*DW-1:0]   delta_flat,
    output logic [ROWS-1:0]      row_en,
    output logic [COLS-1:0]      col_active,
    output logic [COLS-1:0]      pos_pgm,
    output logic [COLS-1:0]      pos_ers,
    output logic [COLS-1:0]      neg_pgm,
    output logic [COLS-1:0]      neg_ers,
    output logic                 busy,
    output logic                 done
);
    localparam int CNTW = $clog2(MAX_W + 1);

    logic [LRW-1:0] lr_q;
    logic           phase_q;
    logic           accept;

    assign busy   = |col_active;
    assign accept = start & ~busy;
    assign done   = phase_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst)
            lr_q <= LRW'(LR_INIT);
        else if (lr_we)
            lr_q <= lr_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b0;
        else if (accept)
            phase_q <= 1'b1;
        else if (!busy)
            phase_q <= 1'b0;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        pulse_req_t req;

        wupd_width #(.DW(DW), .LRW(LRW), .MAX_W(MAX_W)) u_width (
            .delta    (delta_flat[c*DW +: DW]),
            .gate_off (hidden_mode & ~deriv_flag[c]),
            .lr       (lr_q),
            .req      (req)
        );

        wupd_col #(.CNTW(CNTW)) u_col (
            .clk     (clk),
            .rst     (rst),
            .load    (accept),
            .req     (req),
            .active  (col_active[c]),
            .pos_pgm (pos_pgm[c]),
            .pos_ers (pos_ers[c]),
            .neg_pgm (neg_pgm[c]),
            .neg_ers (neg_ers[c])
        );
    end

    wupd_rows #(.ROWS(ROWS)) u_rows (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .spikes (pre_spike),
        .busy   (busy),
        .row_en (row_en)
    );

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (col_active == '0 && row_en == '0));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    // R8
    joint_start_chk: assert property (@(posedge clk) disable iff (rst)
        (|(col_active & ~$past(col_active))) |-> $past(accept));
endmodule

// File: tb/sim_wupd_ctrl.sv
module sim_wupd_ctrl;
    localparam int ROWS = 4, COLS = 4, DW = 8, LRW = 8, MAX_W = 200;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, lr_we = 1'b0, hidden_mode = 1'b0;
    logic [LRW-1:0] lr_in = '0;
    logic [ROWS-1:0] pre_spike = '0;
    logic [COLS-1:0] deriv_flag = '0;
    logic [COLS*DW-1:0] delta_flat = '0;
    logic [ROWS-1:0] row_en;
    logic [COLS-1:0] col_active, pos_pgm, pos_ers, neg_pgm, neg_ers;
    logic busy, done;

    int checks = 0, fails = 0;
    int lr_model = 16;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wupd_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .LRW(LRW), .MAX_W(MAX_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .lr_we(lr_we), .lr_in(lr_in),
        .hidden_mode(hidden_mode), .pre_spike(pre_spike), .deriv_flag(deriv_flag),
        .delta_flat(delta_flat), .row_en(row_en), .col_active(col_active),
        .pos_pgm(pos_pgm), .pos_ers(pos_ers), .neg_pgm(neg_pgm), .neg_ers(neg_ers),
        .busy(busy), .done(done));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input logic signed [DW-1:0] d, input bit gated);
        int mag, v;
        mag = (d < 0) ? -int'(d) : int'(d);
        if (gated) mag = 0;
        v = (mag * lr_model) / 16;
        return (v > MAX_W) ? MAX_W : v;
    endfunction

    task automatic set_lr(input int v);
        @(negedge clk);
        lr_in = LRW'(v); lr_we = 1'b1;
        @(negedge clk);
        lr_we = 1'b0;
        lr_model = v;
    endtask

    // poke: issue a start with other data in the middle of the pulse (R10)
    task automatic run_phase(input logic [ROWS-1:0] sp, input logic [COLS*DW-1:0] d,
                             input logic [COLS-1:0] dv, input bit hid, input bit poke);
        int len [COLS];
        logic [COLS-1:0] negv;
        int maxl = 0;
        for (int c = 0; c < COLS; c++) begin
            len[c] = exp_len(d[c*DW +: DW], hid && !dv[c]);
            negv[c] = d[c*DW + DW-1] && (len[c] != 0);
            if (len[c] > maxl) maxl = len[c];
        end
        @(negedge clk);
        pre_spike = sp; delta_flat = d; deriv_flag = dv; hidden_mode = hid; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= maxl; t++) begin
            logic [COLS-1:0] ea;
            for (int c = 0; c < COLS; c++) ea[c] = (t < len[c]);
            // R3 R7 R8: all columns start together and last their length
            chk(col_active === ea, "R3/R7/R8 col_active", col_active, ea);
            // R4 R5 R6: pulse kinds per sign, program and erase over same cycles
            chk(pos_ers === (ea & ~negv) && neg_pgm === (ea & ~negv), "R4 increase kinds",
                {pos_ers, neg_pgm}, {ea & ~negv, ea & ~negv});
            chk(pos_pgm === (ea & negv) && neg_ers === (ea & negv), "R5/R6 decrease kinds",
                {pos_pgm, neg_ers}, {ea & negv, ea & negv});
            chk(row_en === ((t < maxl) ? sp : '0), "R2 row_en", row_en, (t < maxl) ? sp : '0);
            chk(done === (t == maxl), "R11 done", done, (t == maxl));
            if (poke && t == 1 && maxl > 2) begin
                pre_spike = ~sp; delta_flat = ~d; deriv_flag = ~dv; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done === 1'b0, "R11 done one cycle", done, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({row_en, col_active, pos_pgm, pos_ers, neg_pgm, neg_ers, busy, done} === '0,
            "R1 reset outputs", {row_en, col_active, busy, done}, 0);
        // R1: default gain 1.0 gives length equal to |delta|
        run_phase(4'b1010, {8'sd5, -8'sd3, 8'sd0, 8'sd1}, 4'hF, 1'b0, 1'b0);
        // R3 saturation at both extremes
        set_lr(255);
        run_phase(4'b1111, {8'sd127, -8'sd128, 8'sd1, 8'sd0}, 4'hF, 1'b0, 1'b0);
        // R9 scale down to 0.2 of the gain, approximately 3/16
        set_lr(3);
        run_phase(4'b0110, {8'sd40, -8'sd20, 8'sd5, -8'sd6}, 4'hF, 1'b0, 1'b0);
        // R11 all-zero lengths: done right after start
        run_phase(4'b0001, {8'sd0, 8'sd0, 8'sd0, 8'sd0}, 4'hF, 1'b0, 1'b0);
        // R7 hidden gating, and flags ignored when not hidden
        set_lr(16);
        run_phase(4'b1100, {8'sd9, -8'sd7, 8'sd4, -8'sd2}, 4'b0101, 1'b1, 1'b0);
        run_phase(4'b1100, {8'sd9, -8'sd7, 8'sd4, -8'sd2}, 4'b0101, 1'b0, 1'b0);
        // R9 change of lr during a pulse does not alter it
        begin
            @(negedge clk);
            pre_spike = 4'b0011; delta_flat = {8'sd6, 8'sd6, 8'sd6, 8'sd6}; start = 1'b1;
            @(negedge clk);
            start = 1'b0; lr_in = 8'd200; lr_we = 1'b1;
            @(negedge clk);
            lr_we = 1'b0;
            repeat (4) @(negedge clk);
            chk(col_active === 4'hF, "R9 running pulse keeps length", col_active, 4'hF);
            @(negedge clk);
            chk(col_active === 4'h0 && done === 1'b1, "R9 pulse end", {col_active, done}, 5'h01);
            lr_model = 200;
            set_lr(16);
        end
        // R10 start while busy ignored, then random phases
        run_phase(4'b1001, {-8'sd12, 8'sd30, 8'sd8, -8'sd50}, 4'hF, 1'b0, 1'b1);
        for (int k = 0; k < 40; k++) begin
            logic [COLS*DW-1:0] d;
            for (int c = 0; c < COLS; c++) d[c*DW +: DW] = DW'($urandom_range(0, 255));
            if (k % 10 == 5) set_lr($urandom_range(0, 48));
            run_phase(ROWS'($urandom), d, COLS'($urandom), 1'($urandom), 1'(k % 3 == 0));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule